// File: doc/BRIEF.md
# Bidirectional Cross-Clock Mailbox Pair

This block lets two ports running on unrelated clocks hand single 36-bit words to each other without using a queue. It holds one register for each direction. Port A deposits into the A-to-B register and port B collects from it. The B-to-A register works the same way with the roles swapped. Each port drives one select line. While select is high, that port's write strobe stores its write bus into the outgoing register, and its read strobe captures the incoming register onto its read bus.

A word moves through a toggle handshake. An accepted write flips a writer-side toggle. A synchronizer carries that toggle into the reader's domain, where it raises the mail flag. A read flips a reader-side toggle, and a second synchronizer returns it to the writer, where it clears the busy flag. The register is loaded only while the writer is idle, so it does not change from the write until the acknowledgement returns. This is what makes it safe for the reader's clock to sample it.

Each direction contains two small state machines. The sender is either in TX_IDLE or TX_WAIT. It moves from TX_IDLE to TX_WAIT on an accepted write, and from TX_WAIT back to TX_IDLE when the returned acknowledgement matches its toggle. The receiver is either in RX_EMPTY or RX_FULL. It moves from RX_EMPTY to RX_FULL when the synchronized toggle differs from its acknowledgement toggle, and from RX_FULL back to RX_EMPTY on an accepted read.

Top module: `mbx_pair`

## Requirements
- R1: While a port's reset is low, that port's mail flag, busy flag and read bus are all zero.
- R2: When a port's busy flag is low and it presents select=1 with write=1 at a rising edge, the word is stored and busy reads 1 after that edge.
- R3: While busy is 1, further writes from that port are dropped, and the word stored earlier is what the other port later reads.
- R4: The other port's mail flag rises on the third rising edge of the reader's clock after the edge that accepted the write (two synchronizer stages plus the receiver state register).
- R5: When the mail flag is 1 and the port presents select=1 with read=1 at a rising edge, the stored word appears on its read bus after that edge and its mail flag is 0 after that same edge.
- R6: A read strobe while the mail flag is 0 has no effect: the read bus and the flags keep their values.
- R7: The writer's busy flag falls on the third rising edge of the writer's clock after the edge that accepted the read, and a new write is accepted from then on.
- R8: A write or read strobe with select=0 changes nothing: no word is stored, no mail flag changes, and the read bus holds.
- R9: The two directions operate independently, so both ports may have words in flight at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous reset, active low |
| a_sel | input | 1 | Port A mailbox select |
| a_wr | input | 1 | Port A write strobe |
| a_rd | input | 1 | Port A read strobe |
| a_wdata | input | 36 | Word that port A sends to B |
| a_rdata | output | 36 | Last word that port A collected from B |
| a_mail | output | 1 | A word from B is waiting |
| a_busy | output | 1 | Port A's previous word has not yet been acknowledged |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous reset, active low |
| b_sel | input | 1 | Port B mailbox select |
| b_wr | input | 1 | Port B write strobe |
| b_rd | input | 1 | Port B read strobe |
| b_wdata | input | 36 | Word that port B sends to A |
| b_rdata | output | 36 | Last word that port B collected from A |
| b_mail | output | 1 | A word from A is waiting |
| b_busy | output | 1 | Port B's previous word has not yet been acknowledged |

## Verification
Busy and the read bus respond one edge after an accepted write or read. The mail flag rises on the third reader edge after a write, and busy falls on the third writer edge after a read. A behavioural model in the bench counts those edges per direction and is compared 0.2 ns after every edge of each clock. Stimulus changes 1 ns after an edge, and the two clocks are placed so that their edges never coincide. As a result, the edge at which each output is due can be identified without ambiguity.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    parameter int MBX_W       = 36;
    parameter int MBX_SYNC_N  = 2;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_WAIT = 1'b1
    } tx_state_t;

    typedef enum logic {
        RX_EMPTY = 1'b0,
        RX_FULL  = 1'b1
    } rx_state_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_send.sv
module mbx_send
    import mbx_pkg::*;
#(
    parameter int W      = MBX_W,
    parameter int SYNC_N = MBX_SYNC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         ack_tog,
    output logic         busy,
    output logic         tog,
    output logic [W-1:0] word
);
    tx_state_t    state_q, state_d;
    logic         ack_s;
    logic         accept;
    logic         tog_q;
    logic [W-1:0] word_q;

    mbx_sync #(.STAGES(SYNC_N)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_tog),
        .q     (ack_s)
    );

    assign accept = sel && wr && (state_q == TX_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (accept)         state_d = TX_WAIT;
            TX_WAIT: if (ack_s == tog_q) state_d = TX_IDLE;
            default:                     state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            tog_q   <= 1'b0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                tog_q  <= ~tog_q;
                word_q <= wdata;
            end
        end
    end

    always_comb begin
        busy = (state_q == TX_WAIT);
        tog  = tog_q;
        word = word_q;
    end

    assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sel && wr) |=> (busy && word_q == $past(wdata)));

    assert_hold_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(word_q));

    assert_nosel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && wr) |=> ($stable(word_q) && $stable(tog_q)));
endmodule

// File: rtl/mbx_recv.sv
module mbx_recv
    import mbx_pkg::*;
#(
    parameter int W      = MBX_W,
    parameter int SYNC_N = MBX_SYNC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel,
    input  logic         rd,
    input  logic         tog_in,
    input  logic [W-1:0] word_in,
    output logic         mail,
    output logic         ack_tog,
    output logic [W-1:0] rdata
);
    rx_state_t    state_q, state_d;
    logic         tog_s;
    logic         take;
    logic         ack_q;
    logic [W-1:0] rdata_q;

    mbx_sync #(.STAGES(SYNC_N)) u_tog_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (tog_in),
        .q     (tog_s)
    );

    assign take = sel && rd && (state_q == RX_FULL);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY: if (tog_s != ack_q) state_d = RX_FULL;
            RX_FULL:  if (take)           state_d = RX_EMPTY;
            default:                      state_d = RX_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_EMPTY;
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                ack_q   <= ~ack_q;
                rdata_q <= word_in;
            end
        end
    end

    always_comb begin
        mail    = (state_q == RX_FULL);
        ack_tog = ack_q;
        rdata   = rdata_q;
    end

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mail && sel && rd) |=> (!mail && rdata == $past(word_in)));

    assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mail |=> $stable(rdata));

    assert_nosel_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mail && !sel) |=> (mail && $stable(rdata)));
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
    import mbx_pkg::*;
#(
    parameter int DATA_W      = MBX_W,
    parameter int SYNC_STAGES = MBX_SYNC_N
) (
    input  logic              clk_a,
    input  logic              rst_a_n,
    input  logic              a_sel,
    input  logic              a_wr,
    input  logic              a_rd,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_mail,
    output logic              a_busy,
    input  logic              clk_b,
    input  logic              rst_b_n,
    input  logic              b_sel,
    input  logic              b_wr,
    input  logic              b_rd,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_mail,
    output logic              b_busy
);
    localparam int NPORT = 2;

    logic              clk_v   [NPORT];
    logic              rst_v   [NPORT];
    logic              sel_v   [NPORT];
    logic              wr_v    [NPORT];
    logic              rd_v    [NPORT];
    logic [DATA_W-1:0] wdata_v [NPORT];
    logic [DATA_W-1:0] rdata_v [NPORT];
    logic              mail_v  [NPORT];
    logic              busy_v  [NPORT];
    logic              tog_v   [NPORT];
    logic              ack_v   [NPORT];
    logic [DATA_W-1:0] word_v  [NPORT];

    assign clk_v[0]   = clk_a;   assign clk_v[1]   = clk_b;
    assign rst_v[0]   = rst_a_n; assign rst_v[1]   = rst_b_n;
    assign sel_v[0]   = a_sel;   assign sel_v[1]   = b_sel;
    assign wr_v[0]    = a_wr;    assign wr_v[1]    = b_wr;
    assign rd_v[0]    = a_rd;    assign rd_v[1]    = b_rd;
    assign wdata_v[0] = a_wdata; assign wdata_v[1] = b_wdata;

    // Channel c is written by port c and read by port 1-c.
    generate
        for (genvar c = 0; c < NPORT; c++) begin : g_chan
            localparam int RX = NPORT - 1 - c;

            mbx_send #(.W(DATA_W), .SYNC_N(SYNC_STAGES)) u_send (
                .clk     (clk_v[c]),
                .rst_n   (rst_v[c]),
                .sel     (sel_v[c]),
                .wr      (wr_v[c]),
                .wdata   (wdata_v[c]),
                .ack_tog (ack_v[c]),
                .busy    (busy_v[c]),
                .tog     (tog_v[c]),
                .word    (word_v[c])
            );

            mbx_recv #(.W(DATA_W), .SYNC_N(SYNC_STAGES)) u_recv (
                .clk     (clk_v[RX]),
                .rst_n   (rst_v[RX]),
                .sel     (sel_v[RX]),
                .rd      (rd_v[RX]),
                .tog_in  (tog_v[c]),
                .word_in (word_v[c]),
                .mail    (mail_v[RX]),
                .ack_tog (ack_v[c]),
                .rdata   (rdata_v[RX])
            );
        end
    endgenerate

    assign a_busy  = busy_v[0];
    assign b_busy  = busy_v[1];
    assign a_mail  = mail_v[0];
    assign b_mail  = mail_v[1];
    assign a_rdata = rdata_v[0];
    assign b_rdata = rdata_v[1];
endmodule

// File: tb/sim_mbx_pair.sv
module sim_mbx_pair;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int W = 36;

    logic         clk_a = 1'b0, clk_b = 1'b0;
    logic         rst_a_n = 1'b0, rst_b_n = 1'b0;
    logic         a_sel = 0, a_wr = 0, a_rd = 0, b_sel = 0, b_wr = 0, b_rd = 0;
    logic [W-1:0] a_wdata = '0, b_wdata = '0;
    logic [W-1:0] a_rdata, b_rdata;
    logic         a_mail, a_busy, b_mail, b_busy;

    int total = 0;
    int bad   = 0;

    // 200 MHz port A clock, edges at x.5 ns; port B edges at whole ns, never coincident.
    always #2.5 clk_a = ~clk_a;
    initial begin
        #1 clk_b = 1'b1;
        forever #3.5 clk_b = ~clk_b;
    end

    mbx_pair u0 (
        .clk_a(clk_a), .rst_a_n(rst_a_n), .a_sel(a_sel), .a_wr(a_wr), .a_rd(a_rd),
        .a_wdata(a_wdata), .a_rdata(a_rdata), .a_mail(a_mail), .a_busy(a_busy),
        .clk_b(clk_b), .rst_b_n(rst_b_n), .b_sel(b_sel), .b_wr(b_wr), .b_rd(b_rd),
        .b_wdata(b_wdata), .b_rdata(b_rdata), .b_mail(b_mail), .b_busy(b_busy)
    );

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: index = channel (0: A to B, 1: B to A).
    logic         m_busy [2] = '{0, 0};
    logic         m_full [2] = '{0, 0};
    logic [W-1:0] m_word [2] = '{0, 0};
    logic [W-1:0] m_rdat [2] = '{0, 0};
    int           wr_pend [2] = '{0, 0};
    int           wr_cnt  [2] = '{0, 0};
    int           ak_pend [2] = '{0, 0};
    int           ak_cnt  [2] = '{0, 0};

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_busy[c] = 0; m_full[c] = 0; m_word[c] = '0; m_rdat[c] = '0;
            wr_pend[c] = 0; wr_cnt[c] = 0; ak_pend[c] = 0; ak_cnt[c] = 0;
        end
    endtask

    task automatic writer_edge(input int c, input logic s, input logic w,
                               input logic [W-1:0] d);
        if (m_busy[c]) begin
            if (ak_pend[c] != 0) begin
                ak_cnt[c]++;
                if (ak_cnt[c] == 3) begin m_busy[c] = 0; ak_pend[c] = 0; end
            end
        end else if (s && w) begin
            m_word[c] = d; m_busy[c] = 1; wr_pend[c] = 1; wr_cnt[c] = 0;
        end
    endtask

    task automatic reader_edge(input int c, input logic s, input logic r);
        if (m_full[c]) begin
            if (s && r) begin
                m_rdat[c] = m_word[c]; m_full[c] = 0; ak_pend[c] = 1; ak_cnt[c] = 0;
            end
        end else if (wr_pend[c] != 0) begin
            wr_cnt[c]++;
            if (wr_cnt[c] == 3) begin m_full[c] = 1; wr_pend[c] = 0; end
        end
    endtask

    always @(posedge clk_a) begin
        if (!rst_a_n) model_reset();
        else begin
            writer_edge(0, a_sel, a_wr, a_wdata);
            reader_edge(1, a_sel, a_rd);
            #0.2;
            chk(a_busy == m_busy[0], "R2/R7 a_busy", W'(a_busy), W'(m_busy[0]));
            chk(a_mail == m_full[1], "R4 a_mail", W'(a_mail), W'(m_full[1]));
            chk(a_rdata == m_rdat[1], "R5 a_rdata", a_rdata, m_rdat[1]);
        end
    end

    always @(posedge clk_b) begin
        if (!rst_b_n) model_reset();
        else begin
            writer_edge(1, b_sel, b_wr, b_wdata);
            reader_edge(0, b_sel, b_rd);
            #0.2;
            chk(b_busy == m_busy[1], "R2/R7 b_busy", W'(b_busy), W'(m_busy[1]));
            chk(b_mail == m_full[0], "R4 b_mail", W'(b_mail), W'(m_full[0]));
            chk(b_rdata == m_rdat[0], "R5 b_rdata", b_rdata, m_rdat[0]);
        end
    end

    task automatic a_set(input logic s, input logic w, input logic r,
                         input logic [W-1:0] d);
        @(posedge clk_a); #1;
        a_sel = s; a_wr = w; a_rd = r; a_wdata = d;
    endtask

    task automatic b_set(input logic s, input logic w, input logic r,
                         input logic [W-1:0] d);
        @(posedge clk_b); #1;
        b_sel = s; b_wr = w; b_rd = r; b_wdata = d;
    endtask

    localparam logic [W-1:0] W1  = 36'h9_A5A5_1234;
    localparam logic [W-1:0] W2  = 36'h3_0000_FFFF;
    localparam logic [W-1:0] WB  = 36'hC_5A5A_0F0F;
    localparam logic [W-1:0] BAD = 36'h0_DEAD_BEEF;

    task automatic port_a_script();
        for (int i = 0; i < 8; i++) a_set(0, 0, 0, '0);
        a_set(1, 1, 0, W1);
        a_set(1, 1, 0, BAD);
        chk(a_busy == 1'b1, "R2 busy after write", W'(a_busy), W'(1));
        for (int i = 0; i < 3; i++) a_set(1, 1, 0, BAD);   // R3: dropped while busy
        for (int i = 0; i < 2; i++) a_set(0, 1, 0, ~W1);   // R8: no select
        a_set(0, 0, 0, '0);
        for (int n = 0; n < 400 && a_busy; n++) begin @(posedge clk_a); #1; end
        chk(a_busy == 1'b0, "R7 busy released", W'(a_busy), W'(0));
        for (int n = 0; n < 400 && !a_mail; n++) begin @(posedge clk_a); #1; end
        a_set(1, 0, 1, '0);
        a_set(0, 0, 0, '0);
        chk(a_rdata == WB, "R9 word from B", a_rdata, WB);
        chk(a_mail == 1'b0, "R5 mail cleared", W'(a_mail), W'(0));
        a_set(1, 1, 0, W2);
        a_set(0, 0, 0, '0);
        for (int n = 0; n < 400 && a_busy; n++) begin @(posedge clk_a); #1; end
        chk(a_busy == 1'b0, "R7 second release", W'(a_busy), W'(0));
    endtask

    task automatic port_b_script();
        b_set(0, 0, 0, '0);
        b_set(0, 0, 0, '0);
        for (int i = 0; i < 3; i++) b_set(1, 0, 1, '0);   // R6: reads with no mail
        b_set(0, 0, 0, '0);
        chk(b_rdata == '0, "R6 empty read rdata", b_rdata, '0);
        chk(b_mail == 1'b0, "R6 empty read mail", W'(b_mail), W'(0));
        b_set(1, 1, 0, WB);
        b_set(0, 0, 0, '0);
        for (int n = 0; n < 400 && !b_mail; n++) begin @(posedge clk_b); #1; end
        for (int i = 0; i < 2; i++) b_set(0, 0, 1, '0);   // R8: read without select
        b_set(0, 0, 0, '0);
        chk(b_mail == 1'b1, "R8 mail kept", W'(b_mail), W'(1));
        chk(b_rdata == '0, "R8 rdata kept", b_rdata, '0);
        b_set(1, 0, 1, '0);
        b_set(0, 0, 0, '0);
        chk(b_rdata == W1, "R3 first word kept", b_rdata, W1);
        for (int n = 0; n < 400 && !b_mail; n++) begin @(posedge clk_b); #1; end
        b_set(1, 0, 1, '0);
        b_set(0, 0, 0, '0);
        chk(b_rdata == W2, "R5 second word", b_rdata, W2);
    endtask

    initial begin
        #10;
        chk(a_mail == 0 && a_busy == 0 && a_rdata == '0, "R1 port A reset",
            a_rdata, '0);
        chk(b_mail == 0 && b_busy == 0 && b_rdata == '0, "R1 port B reset",
            b_rdata, '0);
        #10.3;
        rst_a_n = 1'b1;
        rst_b_n = 1'b1;
        fork
            port_a_script();
            port_b_script();
        join
        repeat (10) @(posedge clk_a);
        #1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule